// File: doc/BRIEF.md
# Grouped Event Selection Matrix

This block sits between the cache's raw event sources and the performance counter bank. Events are organised as a grid: eight group columns, each able to present one 8-bit event code per cycle on its own lane. A single 64-bit selection word picks, for every group, the one code that group watches for. A match on a group lane produces a hit for that group only. This makes selection exclusive per column: two codes of the same group can never be counted at the same time.

Each counter does not name a full event. It names a group through a small type register and follows whatever code that group currently selects. A per-counter filter word then qualifies the hit by the subunit the event came from and by its originating CPU, or by the absence of a CPU tag. A global enable bit in the selection word gates every counter pulse. A separate cycle pulse feeds the cycle counter and lies outside the group scheme. Configuration arrives over a simple write port. An event identifier in software form packs the code in bits 11:4 and the group in bits 3:0, so a write of the selection word places code CC of group G at bits 8G+7..8G.

Top module: `grp_event_matrix`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `cnt_pulse` and `cyc_pulse` are 0. Reset clears the selection word, every type register and every filter word.
- R2: Events use one lane per group g, with code `ev_code[8g+7:8g]`. The selection word stores group g's code at bits 8g+7..8g. Group 7's stored code uses bits 62:56 with its top bit taken as 0. When lane g is valid and its code equals the stored code, every counter whose type register holds g raises its `cnt_pulse` bit in the cycle after the event, provided the filter passes and the matrix is enabled.
- R3: A valid event whose code differs from its group's stored code produces no pulse.
- R4: When bit 63 of the selection word is 0, no `cnt_pulse` bit is raised.
- R5: A type register value of 8 to 15 selects no group, and that counter never pulses.
- R6: Code 0xFE is reserved for the cycle counter. A group event carrying 0xFE never produces a counter pulse.
- R7: Filter bits 17, 18 and 19 admit subunits 0, 1 and 2 (`ev_sub` per lane, 2 bits). Subunit 3 is never admitted.
- R8: For an event with `ev_noid` 0, filter bit 0 or bit 1 admits CPU 0 or CPU 1 (`ev_cpu`). For an event with `ev_noid` 1, filter bit 2 admits it.
- R9: Several counters may follow the same group and then pulse together. Counters following different groups pulse independently in the same cycle.
- R10: A new selection word takes effect from the cycle after its write. An event in the same cycle as the write is compared against the old code.
- R11: `cyc_pulse` is 1 in every cycle from the second cycle after reset release, independent of the selection word.
- R12: Writes use `cfg_kind` 0 for the selection word, 1 for the type register of counter `cfg_idx` (value in bits 3:0), and 2 for the filter word of counter `cfg_idx`. A write with `cfg_kind` 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Target: 0 selection, 1 type, 2 filter, 3 none |
| cfg_idx | input | 3 | Counter index for type and filter writes |
| cfg_wdata | input | 64 | Write data |
| ev_valid | input | 8 | Per-group event valid |
| ev_code | input | 64 | Per-group 8-bit event code, group g at 8g+7..8g |
| ev_cpu | input | 8 | Per-group originating CPU (0 or 1) |
| ev_noid | input | 8 | Per-group flag: event carries no CPU ID |
| ev_sub | input | 16 | Per-group 2-bit subunit, group g at 2g+1..2g |
| cnt_pulse | output | 8 | One count pulse per event counter |
| cyc_pulse | output | 1 | Free-running pulse for the cycle counter |

## Verification
The hardest case to reach is the write-versus-event race of R10. It needs a selection write and a matching lane event in the same cycle, followed by events for the old and new codes in the next cycles. The stimulus drives both the write strobe and the event lane on one falling edge, then steps through the two codes one cycle at a time. A further corner is group 7, whose stored code loses its top bit because bit 63 is the enable. The bench drives matching and non-matching codes on lane 7 to show the truncation. Filter qualification is reached by retargeting single counters while the rest keep the open filter, so a pulse mask shows exactly which counter was filtered.

// File: rtl/evmx_pkg.sv
package evmx_pkg;

    localparam int GROUPS     = 8;
    localparam int CODE_W     = 8;
    localparam int GRP_W      = 4;
    localparam int GI_W       = $clog2(GROUPS);
    localparam int SEL_W      = GROUPS * CODE_W;
    localparam int EN_BIT     = SEL_W - 1;
    localparam logic [CODE_W-1:0] CYCLE_CODE = 8'hFE;
    localparam int SUB_N      = 3;
    localparam int SUB_LO     = 17;
    localparam int NOID_BIT   = 2;
    localparam int CPU_N      = 2;

    typedef enum logic [1:0] {
        CFG_SEL  = 2'd0,
        CFG_TYPE = 2'd1,
        CFG_FILT = 2'd2,
        CFG_NONE = 2'd3
    } cfg_kind_e;

    typedef struct packed {
        logic       cpu;
        logic       noid;
        logic [1:0] sub;
    } ev_attr_t;

    typedef struct packed {
        logic [SUB_N-1:0] sub_en;
        logic             noid_en;
        logic [CPU_N-1:0] cpu_en;
    } filt_t;

    // Stored code for group g; the last group loses its top bit to the enable.
    function automatic logic [CODE_W-1:0] sel_code(input logic [SEL_W-1:0] s, input int g);
        logic [CODE_W-1:0] c;
        c = s[g*CODE_W +: CODE_W];
        if (g == GROUPS - 1) c[CODE_W-1] = 1'b0;
        return c;
    endfunction

    function automatic filt_t filt_decode(input logic [SEL_W-1:0] w);
        filt_t f;
        f.sub_en  = w[SUB_LO +: SUB_N];
        f.noid_en = w[NOID_BIT];
        f.cpu_en  = w[CPU_N-1:0];
        return f;
    endfunction

    function automatic logic filt_pass(input filt_t f, input ev_attr_t a);
        logic [3:0] sub_vec;
        logic       src_ok;
        sub_vec = {1'b0, f.sub_en};
        src_ok  = a.noid ? f.noid_en : f.cpu_en[a.cpu];
        return sub_vec[a.sub] & src_ok;
    endfunction

endpackage

// File: rtl/evmx_cfg.sv
module evmx_cfg
    import evmx_pkg::*;
#(
    parameter int NUM_CTRS = 8,
    parameter int IDX_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  cfg_kind_e            kind,
    input  logic [IDX_W-1:0]     idx,
    input  logic [SEL_W-1:0]     wdata,
    output logic [SEL_W-1:0]     sel_q,
    output logic [GRP_W-1:0]     type_q [NUM_CTRS],
    output filt_t                filt_q [NUM_CTRS]
);

    always_ff @(posedge clk) begin
        if (rst)                        sel_q <= '0;
        else if (we && kind == CFG_SEL) sel_q <= wdata;
    end

    for (genvar i = 0; i < NUM_CTRS; i++) begin : g_ctr
        logic hit_me;
        assign hit_me = we && (idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                type_q[i] <= '0;
                filt_q[i] <= '0;
            end else if (hit_me) begin
                if (kind == CFG_TYPE) type_q[i] <= wdata[GRP_W-1:0];
                if (kind == CFG_FILT) filt_q[i] <= filt_decode(wdata);
            end
        end
    end

    // R12
    ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
        (we && kind == CFG_NONE) |=> $stable(sel_q));

endmodule

// File: rtl/evmx_grp_match.sv
module evmx_grp_match
    import evmx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SEL_W-1:0]     sel_q,
    input  logic [GROUPS-1:0]    ev_valid,
    input  logic [SEL_W-1:0]     ev_code,
    output logic [GROUPS-1:0]    hit
);

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic [CODE_W-1:0] want;
        logic [CODE_W-1:0] got;

        assign want   = sel_code(sel_q, g);
        assign got    = ev_code[g*CODE_W +: CODE_W];
        assign hit[g] = ev_valid[g] && (got == want) && (want != CYCLE_CODE);

        // R6
        reserved_code_chk: assert property (@(posedge clk) disable iff (rst)
            (got == CYCLE_CODE) |-> !hit[g]);
    end

endmodule

// File: rtl/evmx_route.sv
module evmx_route
    import evmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [GRP_W-1:0]  type_i,
    input  filt_t             filt,
    input  logic [GROUPS-1:0] hit,
    input  ev_attr_t          attrs [GROUPS],
    output logic              pulse_q
);

    logic              grp_ok;
    logic [GI_W-1:0]   gsel;
    logic              qual;

    assign grp_ok = (type_i < GRP_W'(GROUPS));
    assign gsel   = type_i[GI_W-1:0];

    always_comb begin
        qual = 1'b0;
        if (grp_ok) qual = hit[gsel] && filt_pass(filt, attrs[gsel]);
    end

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= en && qual;
    end

    // R4
    matrix_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pulse_q);

    // R5
    bad_group_chk: assert property (@(posedge clk) disable iff (rst)
        (type_i >= GRP_W'(GROUPS)) |=> !pulse_q);

    // R3
    no_event_chk: assert property (@(posedge clk) disable iff (rst)
        (hit == '0) |=> !pulse_q);

endmodule

// File: rtl/grp_event_matrix.sv
module grp_event_matrix
    import evmx_pkg::*;
#(
    parameter int NUM_CTRS = 8,
    parameter int IDX_W    = (NUM_CTRS > 1) ? $clog2(NUM_CTRS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [1:0]             cfg_kind,
    input  logic [IDX_W-1:0]       cfg_idx,
    input  logic [SEL_W-1:0]       cfg_wdata,
    input  logic [GROUPS-1:0]      ev_valid,
    input  logic [SEL_W-1:0]       ev_code,
    input  logic [GROUPS-1:0]      ev_cpu,
    input  logic [GROUPS-1:0]      ev_noid,
    input  logic [2*GROUPS-1:0]    ev_sub,
    output logic [NUM_CTRS-1:0]    cnt_pulse,
    output logic                   cyc_pulse
);

    logic [SEL_W-1:0]  sel_q;
    logic [GRP_W-1:0]  type_q [NUM_CTRS];
    filt_t             filt_q [NUM_CTRS];
    logic [GROUPS-1:0] hit;
    ev_attr_t          attrs [GROUPS];
    logic              cyc_q;

    for (genvar g = 0; g < GROUPS; g++) begin : g_attr
        assign attrs[g].cpu  = ev_cpu[g];
        assign attrs[g].noid = ev_noid[g];
        assign attrs[g].sub  = ev_sub[2*g +: 2];
    end

    evmx_cfg #(.NUM_CTRS(NUM_CTRS), .IDX_W(IDX_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .kind   (cfg_kind_e'(cfg_kind)),
        .idx    (cfg_idx),
        .wdata  (cfg_wdata),
        .sel_q  (sel_q),
        .type_q (type_q),
        .filt_q (filt_q)
    );

    evmx_grp_match u_match (
        .clk      (clk),
        .rst      (rst),
        .sel_q    (sel_q),
        .ev_valid (ev_valid),
        .ev_code  (ev_code),
        .hit      (hit)
    );

    for (genvar i = 0; i < NUM_CTRS; i++) begin : g_route
        evmx_route u_route (
            .clk     (clk),
            .rst     (rst),
            .en      (sel_q[EN_BIT]),
            .type_i  (type_q[i]),
            .filt    (filt_q[i]),
            .hit     (hit),
            .attrs   (attrs),
            .pulse_q (cnt_pulse[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) cyc_q <= 1'b0;
        else     cyc_q <= 1'b1;
    end
    assign cyc_pulse = cyc_q;

    // R11
    cycle_run_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> cyc_pulse);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (cnt_pulse == '0 && !cyc_pulse));

endmodule

// File: tb/test_grp_event_matrix.sv
`timescale 1ns/1ps
module test_grp_event_matrix;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_kind = 2'd0;
    logic [2:0]  cfg_idx = 3'd0;
    logic [63:0] cfg_wdata = '0;
    logic [7:0]  ev_valid = '0;
    logic [63:0] ev_code = '0;
    logic [7:0]  ev_cpu = '0;
    logic [7:0]  ev_noid = '0;
    logic [15:0] ev_sub = '0;
    logic [7:0]  cnt_pulse;
    logic        cyc_pulse;

    int errs = 0;
    int chks = 0;
    bit done = 0;

    localparam logic [63:0] OPEN_FILT = 64'h000E_0007;

    always #4 clk = ~clk;

    grp_event_matrix i_grp_event_matrix (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .ev_valid(ev_valid),
        .ev_code(ev_code), .ev_cpu(ev_cpu), .ev_noid(ev_noid),
        .ev_sub(ev_sub), .cnt_pulse(cnt_pulse), .cyc_pulse(cyc_pulse)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        chks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] kind, input int idx, input logic [63:0] data);
        cfg_we = 1'b1; cfg_kind = kind; cfg_idx = 3'(idx); cfg_wdata = data;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic clr_ev;
        ev_valid = '0; ev_code = '0; ev_cpu = '0; ev_noid = '0; ev_sub = '0;
    endtask

    task automatic put_ev(input int g, input logic [7:0] code, input logic cpu,
                          input logic noid, input logic [1:0] sub);
        ev_valid[g] = 1'b1;
        ev_code[g*8 +: 8] = code;
        ev_cpu[g] = cpu;
        ev_noid[g] = noid;
        ev_sub[2*g +: 2] = sub;
    endtask

    task automatic fire_chk(input string req, input logic [7:0] exp);
        tick();
        check(req, cnt_pulse, exp);
        clr_ev();
    endtask

    function automatic logic [63:0] base_sel(input logic en);
        logic [63:0] s;
        for (int g = 0; g < 8; g++) s[g*8 +: 8] = 8'(8'h10 + g);
        s[63] = en;
        return s;
    endfunction

    task automatic setup;
        wr(2'd0, 0, base_sel(1'b1));
        for (int i = 0; i < 8; i++) begin
            wr(2'd1, i, 64'(i));
            wr(2'd2, i, OPEN_FILT);
        end
    endtask

    task automatic t_reset;
        for (int g = 0; g < 8; g++) put_ev(g, 8'h00, 1'b0, 1'b0, 2'd0);
        tick();
        check("R1 pulses in reset", cnt_pulse, 8'h00);
        check("R1 cycle in reset", {7'd0, cyc_pulse}, 8'h00);
        rst = 1'b0;
        tick();
        check("R1 pulses after release", cnt_pulse, 8'h00);
        check("R1 cycle first cycle", {7'd0, cyc_pulse}, 8'h01);
        clr_ev();
    endtask

    task automatic t_match;
        for (int g = 0; g < 8; g++) begin
            put_ev(g, 8'(8'h10 + g), 1'b0, 1'b0, 2'd0);
            fire_chk("R2 single group hit", 8'(1 << g));
        end
        put_ev(7, 8'h97, 1'b0, 1'b0, 2'd0);
        fire_chk("R2 group7 top bit not stored", 8'h00);
    endtask

    task automatic t_mismatch;
        put_ev(3, 8'h44, 1'b0, 1'b0, 2'd0);
        fire_chk("R3 wrong code", 8'h00);
        put_ev(1, 8'h10, 1'b0, 1'b0, 2'd0);
        fire_chk("R3 other group code", 8'h00);
    endtask

    task automatic t_shared;
        wr(2'd1, 5, 64'd2);
        put_ev(2, 8'h12, 1'b0, 1'b0, 2'd0);
        fire_chk("R9 shared group", 8'h24);
        put_ev(2, 8'h12, 1'b0, 1'b0, 2'd0);
        put_ev(6, 8'h16, 1'b1, 1'b0, 2'd1);
        fire_chk("R9 independent groups", 8'h64);
        wr(2'd1, 5, 64'd5);
    endtask

    task automatic t_bad_group;
        wr(2'd1, 3, 64'd9);
        for (int g = 0; g < 8; g++) put_ev(g, 8'(8'h10 + g), 1'b0, 1'b0, 2'd0);
        fire_chk("R5 undecodable group", 8'hF7);
        wr(2'd1, 3, 64'd3);
    endtask

    task automatic t_reserved;
        logic [63:0] s;
        s = base_sel(1'b1);
        s[39:32] = 8'hFE;
        wr(2'd0, 0, s);
        put_ev(4, 8'hFE, 1'b0, 1'b0, 2'd0);
        fire_chk("R6 reserved code", 8'h00);
        wr(2'd0, 0, base_sel(1'b1));
    endtask

    task automatic t_filt_sub;
        wr(2'd2, 1, 64'h0004_0007);
        put_ev(1, 8'h11, 1'b0, 1'b0, 2'd0);
        fire_chk("R7 subunit0 blocked", 8'h00);
        put_ev(1, 8'h11, 1'b0, 1'b0, 2'd1);
        fire_chk("R7 subunit1 passed", 8'h02);
        wr(2'd2, 1, OPEN_FILT);
        put_ev(1, 8'h11, 1'b0, 1'b0, 2'd3);
        fire_chk("R7 subunit3 never", 8'h00);
    endtask

    task automatic t_filt_cpu;
        wr(2'd2, 0, 64'h000E_0002);
        put_ev(0, 8'h10, 1'b0, 1'b0, 2'd0);
        fire_chk("R8 cpu0 blocked", 8'h00);
        put_ev(0, 8'h10, 1'b1, 1'b0, 2'd2);
        fire_chk("R8 cpu1 passed", 8'h01);
        put_ev(0, 8'h10, 1'b1, 1'b1, 2'd0);
        fire_chk("R8 noid blocked", 8'h00);
        wr(2'd2, 0, 64'h000E_0004);
        put_ev(0, 8'h10, 1'b0, 1'b1, 2'd0);
        fire_chk("R8 noid passed", 8'h01);
        put_ev(0, 8'h10, 1'b1, 1'b0, 2'd0);
        fire_chk("R8 cpu1 blocked by noid-only", 8'h00);
        wr(2'd2, 0, OPEN_FILT);
    endtask

    task automatic t_enable;
        wr(2'd0, 0, base_sel(1'b0));
        for (int g = 0; g < 8; g++) put_ev(g, 8'(8'h10 + g), 1'b0, 1'b0, 2'd0);
        fire_chk("R4 matrix disabled", 8'h00);
        wr(2'd0, 0, base_sel(1'b1));
        for (int g = 0; g < 8; g++) put_ev(g, 8'(8'h10 + g), 1'b0, 1'b0, 2'd0);
        fire_chk("R4 matrix re-enabled", 8'hFF);
    endtask

    task automatic t_switch;
        logic [63:0] s;
        s = base_sel(1'b1);
        s[7:0] = 8'h55;
        cfg_we = 1'b1; cfg_kind = 2'd0; cfg_idx = 3'd0; cfg_wdata = s;
        put_ev(0, 8'h10, 1'b0, 1'b0, 2'd0);
        tick();
        cfg_we = 1'b0;
        check("R10 same-cycle uses old code", cnt_pulse, 8'h01);
        clr_ev();
        put_ev(0, 8'h55, 1'b0, 1'b0, 2'd0);
        fire_chk("R10 new code active", 8'h01);
        put_ev(0, 8'h10, 1'b0, 1'b0, 2'd0);
        fire_chk("R10 old code dropped", 8'h00);
        wr(2'd0, 0, base_sel(1'b1));
    endtask

    task automatic t_ignored;
        wr(2'd3, 0, 64'h0);
        put_ev(0, 8'h10, 1'b0, 1'b0, 2'd0);
        fire_chk("R12 kind3 leaves selection", 8'h01);
        put_ev(4, 8'h14, 1'b1, 1'b0, 2'd2);
        fire_chk("R12 kind3 leaves type and filter", 8'h10);
    endtask

    task automatic t_cycle;
        int bad = 0;
        for (int k = 0; k < 20; k++) begin
            tick();
            if (cyc_pulse !== 1'b1) bad++;
        end
        check("R11 cycle pulse steady", 8'(bad), 8'h00);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errs++;
            chks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, chks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        setup();
        t_match();
        t_mismatch();
        t_shared();
        t_bad_group();
        t_reserved();
        t_filt_sub();
        t_filt_cpu();
        t_enable();
        t_switch();
        t_ignored();
        t_cycle();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end

endmodule